// File: doc/BRIEF.md
# Locked Key Delivery Unit

This block carries a 32-bit locking key from an on-chip non-volatile store into a bank of key registers, and those registers drive the key-gates of a small locked datapath. The key is absent from the logic at manufacture. After reset a boot sequencer reads it from a storage model, one 8-bit word per cycle, and fills the registers. Only then is the protected result released.

Whenever the protected function is inactive, the key registers are overwritten every cycle with pseudo-random data from a 16-bit LFSR. The LFSR state is copied side by side to fill all 32 key bits. An optical probe that samples the registers while the function is idle therefore sees churning noise instead of the key. When the function becomes active again, the key is fetched from storage again, and the result output stays at zero until that fetch has finished.

The locked datapath computes `(a ^ b) + (a & b)` modulo 256. It has 24 XOR key-gates and 8 multiplexer key-gates. Each gate's built-in polarity cancels the correct key bit, so only the correct key restores the function. The default key value has upper and lower halves that differ, so a replicated LFSR word can never equal it.

Top module: `key_delivery_unit`

## Requirements
- R1: After reset release the key is fetched as four words, lowest word first, one word per cycle, with one cycle of read latency. `key_ready_o` is low during the fetch and rises at the 6th rising clock edge after reset release, one cycle after the last word is written.
- R2: While `key_ready_o` is high, the key registers hold the stored key and `result_o` equals `((data_a_i ^ data_b_i) + (data_a_i & data_b_i))` mod 256.
- R3: While `key_ready_o` is low, `result_o` is zero, whatever the data inputs are.
- R4: When `active_i` is sampled low with the key ready, `key_ready_o` falls at that edge and the unit starts scrambling.
- R5: While scrambling, from the second cycle on, the key registers change every cycle, take values from a never-zero 16-bit LFSR that is replicated across the key width, and never equal the real key.
- R6: When `active_i` is sampled high while scrambling, the key is fetched again. `key_ready_o` rises 6 edges after the edge that started the fetch, which is 7 edges after the edge at which the step that raised `active_i` was applied.
- R7: A fetch that has started always completes, even if `active_i` falls during it. The key is then ready for one cycle and scrambling begins at the next edge if `active_i` is still low.
- R8: In the locked datapath, flipping any single XOR key bit from its correct value corrupts the result for every input. A multiplexer key bit that does not match its correct value selects a decoy net in place of the true net.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| active_i | input | 1 | High while the protected function is in use |
| data_a_i | input | 8 | First operand of the locked function |
| data_b_i | input | 8 | Second operand of the locked function |
| result_o | output | 8 | Locked function result, zero until the key is ready |
| key_ready_o | output | 1 | High while the real key sits in the key registers |

## Verification
Every result is due a fixed number of edges after its stimulus:
- the first ready flag 6 edges after reset release;
- a refetch 7 edges after the step that raised `active_i`;
- the fall of `key_ready_o` one edge after `active_i` is dropped;
- the datapath result in the same cycle as its operands.

The driver applies stimulus 2 ns after a rising edge and queues the expected ready flag and result for that cycle. The monitor compares them at the following falling edge, so each expectation is checked in exactly the cycle it was computed for. Wrong-key corruption is checked on a standalone copy of the locked datapath, which is fed flipped key bits directly.

// File: rtl/kdu_pkg.sv
package kdu_pkg;
  typedef enum logic [1:0] {
    KDU_LOAD     = 2'd0,
    KDU_READY    = 2'd1,
    KDU_SCRAMBLE = 2'd2
  } kdu_state_e;
endpackage

// File: rtl/kdu_key_store.sv
module kdu_key_store #(
  parameter int unsigned KEY_W  = 32,
  parameter int unsigned WORD_W = 8,
  parameter logic [KEY_W-1:0] KEY_VALUE = '0,
  localparam int unsigned NUM_WORDS = KEY_W / WORD_W,
  localparam int unsigned AW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic              rvalid_o,
  output logic [AW-1:0]     raddr_o,
  output logic [WORD_W-1:0] rdata_o
);
  // one-cycle read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      raddr_o  <= '0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) begin
        raddr_o <= rd_addr_i;
        rdata_o <= KEY_VALUE[rd_addr_i*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/kdu_lfsr.sv
module kdu_lfsr #(
  parameter int unsigned LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [LFSR_W-1:0] state_o
);
  logic started_q;

  // Galois form, advances every cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o   <= SEED;
      started_q <= 1'b0;
    end else begin
      state_o   <= (state_o >> 1) ^ (state_o[0] ? TAPS : '0);
      started_q <= 1'b1;
    end
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != '0); // R5
  AST_LFSR_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> !$stable(state_o)); // R5
endmodule

// File: rtl/kdu_boot_seq.sv
module kdu_boot_seq
  import kdu_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  localparam int unsigned AW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned CW = $clog2(NUM_WORDS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          rvalid_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_idx_o,
  output logic          scramble_o,
  output logic          ready_o
);
  kdu_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic last_wr_q;

  assign rd_en_o    = (state_q == KDU_LOAD) && (cnt_q < CW'(NUM_WORDS));
  assign rd_addr_o  = cnt_q[AW-1:0];
  assign wr_en_o    = (state_q == KDU_LOAD) && rvalid_i;
  assign wr_idx_o   = raddr_i;
  assign scramble_o = (state_q == KDU_SCRAMBLE);
  assign ready_o    = (state_q == KDU_READY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= KDU_LOAD;
      cnt_q     <= '0;
      last_wr_q <= 1'b0;
    end else begin
      unique case (state_q)
        KDU_LOAD: begin
          if (rd_en_o) cnt_q <= cnt_q + 1'b1;
          last_wr_q <= wr_en_o && (raddr_i == AW'(NUM_WORDS - 1));
          // ready one cycle after the last word lands
          if (last_wr_q) begin
            state_q   <= KDU_READY;
            last_wr_q <= 1'b0;
          end
        end
        KDU_READY: begin
          if (!active_i) state_q <= KDU_SCRAMBLE;
        end
        KDU_SCRAMBLE: begin
          if (active_i) begin
            state_q <= KDU_LOAD;
            cnt_q   <= '0;
          end
        end
        default: state_q <= KDU_SCRAMBLE;
      endcase
    end
  end

  AST_IDLE_SCRAMBLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !active_i) |=> (scramble_o && !ready_o)); // R4
  AST_ACTIVE_REFETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scramble_o && active_i) |=> rd_en_o); // R6
  AST_FETCH_COMPLETES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == KDU_LOAD) |=> !scramble_o); // R7
  AST_ORDERED_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && rd_addr_o != '0) |-> $past(rd_en_o) && rd_addr_o == $past(rd_addr_o) + 1'b1); // R1
endmodule

// File: rtl/kdu_key_regs.sv
module kdu_key_regs #(
  parameter int unsigned KEY_W  = 32,
  parameter int unsigned WORD_W = 8,
  localparam int unsigned NUM_WORDS = KEY_W / WORD_W,
  localparam int unsigned AW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              scramble_i,
  input  logic [KEY_W-1:0]  rand_i,
  output logic [KEY_W-1:0]  key_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_o[w*WORD_W +: WORD_W] <= '0;
      end else if (scramble_i) begin
        key_o[w*WORD_W +: WORD_W] <= rand_i[w*WORD_W +: WORD_W];
      end else if (wr_en_i && wr_idx_i == AW'(w)) begin
        key_o[w*WORD_W +: WORD_W] <= wr_data_i;
      end
    end
  end

  AST_SCRAMBLE_CHURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scramble_i && $past(scramble_i)) |-> !$stable(key_o)); // R5
endmodule

// File: rtl/kdu_locked_fn.sv
module kdu_locked_fn #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned KEY_W  = 32,
  parameter logic [KEY_W-1:0] KEY_VALUE = '0,
  localparam int unsigned XB = DATA_W,
  localparam int unsigned SB = 2 * DATA_W,
  localparam int unsigned MB = 3 * DATA_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic [DATA_W-1:0] y_o
);
  logic [DATA_W-1:0] n1k, n2k, n3k, sum;

  assign sum = n1k + n2k;

  for (genvar i = 0; i < DATA_W; i++) begin : g_gate
    // XOR key-gates; the constant term is the inverter folded in at lock time
    assign n1k[i] = (a_i[i] ^ b_i[i]) ^ key_i[i]    ^ KEY_VALUE[i];
    assign n2k[i] = (a_i[i] & b_i[i]) ^ key_i[XB+i] ^ KEY_VALUE[XB+i];
    assign n3k[i] = sum[i]            ^ key_i[SB+i] ^ KEY_VALUE[SB+i];
    // mux key-gates: a mismatching key bit picks the decoy net
    if (KEY_VALUE[MB+i]) begin : g_mux_hi
      assign y_o[i] = key_i[MB+i] ? n3k[i] : n1k[i];
    end else begin : g_mux_lo
      assign y_o[i] = key_i[MB+i] ? n1k[i] : n3k[i];
    end
  end
endmodule

// File: rtl/key_delivery_unit.sv
module key_delivery_unit #(
  parameter int unsigned KEY_W  = 32,
  parameter int unsigned WORD_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LFSR_W = 16,
  parameter logic [KEY_W-1:0]  KEY_VALUE = 32'hC35A_96E1,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [DATA_W-1:0] data_a_i,
  input  logic [DATA_W-1:0] data_b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              key_ready_o
);
  localparam int unsigned NUM_WORDS = KEY_W / WORD_W;
  localparam int unsigned AW  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int unsigned REP = (KEY_W + LFSR_W - 1) / LFSR_W;

  logic              rd_en, rvalid, wr_en, scramble;
  logic [AW-1:0]     rd_addr, raddr, wr_idx;
  logic [WORD_W-1:0] rdata;
  logic [LFSR_W-1:0] lfsr;
  logic [REP*LFSR_W-1:0] rand_wide;
  logic [KEY_W-1:0]  key_q;
  logic [DATA_W-1:0] locked_y;

  for (genvar r = 0; r < REP; r++) begin : g_rep
    assign rand_wide[r*LFSR_W +: LFSR_W] = lfsr;
  end

  kdu_key_store #(.KEY_W(KEY_W), .WORD_W(WORD_W), .KEY_VALUE(KEY_VALUE)) u_store (
    .clk_i, .rst_ni, .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rvalid_o(rvalid), .raddr_o(raddr), .rdata_o(rdata)
  );

  kdu_lfsr #(.LFSR_W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk_i, .rst_ni, .state_o(lfsr)
  );

  kdu_boot_seq #(.NUM_WORDS(NUM_WORDS)) u_seq (
    .clk_i, .rst_ni, .active_i, .rvalid_i(rvalid), .raddr_i(raddr),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .scramble_o(scramble), .ready_o(key_ready_o)
  );

  kdu_key_regs #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(rdata),
    .scramble_i(scramble), .rand_i(rand_wide[KEY_W-1:0]), .key_o(key_q)
  );

  kdu_locked_fn #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE)) u_fn (
    .a_i(data_a_i), .b_i(data_b_i), .key_i(key_q), .y_o(locked_y)
  );

  assign result_o = key_ready_o ? locked_y : '0;

  AST_KEY_INTACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ready_o |-> key_q == KEY_VALUE); // R2
  AST_OUT_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_ready_o |-> result_o == '0); // R3
  AST_KEY_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scramble && $past(scramble)) |-> key_q != KEY_VALUE); // R5
endmodule

// File: tb/tb_key_delivery_unit.sv
module tb_key_delivery_unit;
  localparam logic [31:0] KEY = 32'hC35A_96E1;

  logic clk = 1'b0, rst_ni = 1'b0, active = 1'b1;
  logic [7:0] a = '0, b = '0, result;
  logic ready;
  logic [31:0] wkey;
  logic [7:0] wa, wb, wy;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  key_delivery_unit #(.KEY_VALUE(KEY)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .active_i(active), .data_a_i(a),
    .data_b_i(b), .result_o(result), .key_ready_o(ready)
  );

  kdu_locked_fn #(.DATA_W(8), .KEY_W(32), .KEY_VALUE(KEY)) u_wk (
    .a_i(wa), .b_i(wb), .key_i(wkey), .y_o(wy)
  );

  function automatic logic [7:0] ref_fn(input logic [7:0] x, input logic [7:0] y);
    return (x ^ y) + (x & y);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: apply after the edge, queue what this cycle must show
  task automatic step(input logic [7:0] x, input logic [7:0] y, input logic act,
                      input logic exp_rdy, input string tag);
    @(posedge clk);
    #2;
    a = x; b = y; active = act;
    exp_q.push_back({exp_rdy, exp_rdy ? ref_fn(x, y) : 8'h00});
    tag_q.push_back(tag);
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({ready, result} == e, t, {7'd0, ready, result}, {7'd0, e});
    end
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wkey = KEY; wa = '0; wb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ready == 1'b0 && result == 8'h00, "R1 reset state", {7'd0, ready, result}, 16'h0);
    @(posedge clk); #2; rst_ni = 1'b1;

    // R1/R3: fetch takes edges 1..5, ready after edge 6
    for (int i = 1; i <= 5; i++) step(8'h3C + 8'(i), 8'h5A, 1'b1, 1'b0, "R1 R3 boot fetch masks output");
    step(8'h12, 8'h34, 1'b1, 1'b1, "R1 ready at 6th edge");
    // R2: function under several patterns
    step(8'h00, 8'h00, 1'b1, 1'b1, "R2 zeros");
    step(8'hFF, 8'hFF, 1'b1, 1'b1, "R2 ones");
    step(8'h80, 8'h80, 1'b1, 1'b1, "R2 top bits");
    step(8'hA5, 8'h5A, 1'b1, 1'b1, "R2 complement");
    step(8'h0F, 8'h01, 1'b1, 1'b1, "R2 carry chain");
    step(8'hC3, 8'h7E, 1'b1, 1'b1, "R2 mixed");

    // R4: drop active, falls at the sampling edge
    step(8'h11, 8'h22, 1'b0, 1'b1, "R4 ready until sampled");
    for (int i = 0; i < 4; i++) step(8'hF0, 8'h0F, 1'b0, 1'b0, "R4 R3 R5 scrambled and masked");

    // R6: refetch, ready 7 steps after raising active
    step(8'h55, 8'hAA, 1'b1, 1'b0, "R6 raise active");
    for (int i = 0; i < 6; i++) step(8'h77, 8'h99, 1'b1, 1'b0, "R6 refetch in progress");
    step(8'h9C, 8'h63, 1'b1, 1'b1, "R6 ready after refetch");
    step(8'hFE, 8'h02, 1'b1, 1'b1, "R2 after refetch");

    // R6: one-cycle idle pulse
    step(8'h01, 8'h02, 1'b0, 1'b1, "R4 single idle cycle");
    step(8'h03, 8'h04, 1'b1, 1'b0, "R6 pulse scrambled");
    for (int i = 0; i < 6; i++) step(8'h05, 8'h06, 1'b1, 1'b0, "R6 pulse refetch");
    step(8'h44, 8'h88, 1'b1, 1'b1, "R6 pulse ready");

    // R7: active falls mid-fetch; fetch completes, one ready cycle
    step(8'h10, 8'h20, 1'b0, 1'b1, "R7 setup");
    step(8'h10, 8'h20, 1'b0, 1'b0, "R7 setup scramble");
    step(8'h10, 8'h20, 1'b1, 1'b0, "R7 raise active");
    step(8'h10, 8'h20, 1'b1, 1'b0, "R7 fetch");
    step(8'h10, 8'h20, 1'b1, 1'b0, "R7 fetch");
    for (int i = 0; i < 4; i++) step(8'h10, 8'h20, 1'b0, 1'b0, "R7 fetch with active low");
    step(8'hB7, 8'h4D, 1'b0, 1'b1, "R7 fetch completes");
    step(8'hB7, 8'h4D, 1'b0, 1'b0, "R7 then scrambles");

    @(posedge clk);
    @(negedge clk);
    @(negedge clk);

    // R8: standalone locked datapath
    wkey = KEY; wa = 8'h6B; wb = 8'hD2; #1;
    check(wy == ref_fn(wa, wb), "R8 correct key", {8'd0, wy}, {8'd0, ref_fn(wa, wb)});
    for (int k = 0; k < 3; k++) begin
      for (int v = 0; v < 4; v++) begin
        wkey = KEY ^ (32'h1 << (8 * k));
        wa = 8'(v * 37 + 5); wb = 8'(v * 91 + 3); #1;
        check(wy != ref_fn(wa, wb), "R8 flipped XOR key bit", {8'd0, wy}, {8'd0, ~ref_fn(wa, wb)});
      end
    end
    wkey = KEY ^ 32'h0100_0000; wa = 8'h01; wb = 8'h01; #1;
    check(wy == 8'h00, "R8 mux selects decoy", {8'd0, wy}, 16'h0000);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule